// File: doc/BRIEF.md
# Regulator Rail Fault Supervisor

This block watches four regulator rails. Each rail supplies three digital comparator outputs: undervoltage, overcurrent and short-circuit. The block filters these inputs, blanks them while they cannot be trusted, and decides how and when to react to a fault. A fault reaction can switch a rail off at once, request a system power-down, or both. How it reacts depends on the current power state, and a strobe from the sequencer marks the end of each slot.

Every comparator input passes through a saturating deglitch counter. A fault is accepted once the input has stayed asserted for the configured number of consecutive samples.

- Undervoltage and overcurrent are ignored while the rail is in a voltage transition, and while the rail is disabled.
- Short-circuit is ignored for a programmable window after the rail enable rises, so the output can ramp above the threshold first.
- Undervoltage alone can be masked per rail.

Each accepted fault sets a sticky per-rail flag. Software clears a flag with a write-one-to-clear pulse.

When the power state is ACTIVE or STBY, an accepted fault raises the power-down request at once. In the other states, while the sequencer is still bringing the system into ACTIVE, the request is held pending and released at the next slot-end strobe. Overcurrent and short-circuit always switch the affected rail off immediately, whatever the power state.

Top module: `rail_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, every flag, `rail_kill` and `pd_req` are 0.
- R2: An undervoltage or short-circuit fault is accepted at the clock edge that samples the 4th consecutive asserted input. A single deasserted sample restarts the count. The corresponding flag reads 1 from that edge onward.
- R3: The overcurrent deglitch length is 4 samples when `oc_long_sel` is 0 and 32 samples when it is 1.
- R4: While `rail_trans[i]` is 1 or `rail_en[i]` is 0, the undervoltage and overcurrent inputs of rail i are ignored. Counting restarts with the first sample after the transition ends.
- R5: While `uv_mask[i]` is 1, an undervoltage on rail i sets no flag and causes no power-down request.
- R6: Power-state encoding is 0 = INITIALIZE, 1 = sequencing, 2 = ACTIVE, 3 = STBY. In state 2 or 3, an accepted fault makes `pd_req` high for exactly one cycle, registered at the same edge that sets the flag.
- R7: In state 0 or 1, an accepted fault holds the power-down request pending. `pd_req` is then high for one cycle, registered at the edge that samples the next `slot_end`. A `slot_end` with nothing pending raises no request.
- R8: An accepted overcurrent or short-circuit sets `rail_kill[i]` at the same edge as its flag, in every power state. `rail_kill[i]` stays set until an edge samples `rail_en[i]` low. An undervoltage never sets `rail_kill`.
- R9: Short-circuit samples are ignored at the edge that first sees `rail_en[i]` high. They are also ignored at the following `scg_blank_len` edges.
- R10: Flags are sticky. A clear input that is high at an edge clears that flag, but a fault accepted at the same edge wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Power state: 0 INITIALIZE, 1 sequencing, 2 ACTIVE, 3 STBY |
| slot_end | input | 1 | One-cycle strobe at the end of a sequencing slot |
| oc_long_sel | input | 1 | Selects the long overcurrent deglitch length |
| scg_blank_len | input | 8 | Short-circuit blanking length in cycles after enable |
| rail_en | input | 4 | Per-rail enable |
| rail_trans | input | 4 | Per-rail voltage-transition-in-progress flag |
| uv_mask | input | 4 | Per-rail undervoltage mask |
| uv_raw | input | 4 | Undervoltage comparator outputs |
| oc_raw | input | 4 | Overcurrent comparator outputs |
| scg_raw | input | 4 | Short-circuit comparator outputs |
| clr_uv | input | 4 | Clear pulses for the undervoltage flags |
| clr_oc | input | 4 | Clear pulses for the overcurrent flags |
| clr_scg | input | 4 | Clear pulses for the short-circuit flags |
| rail_kill | output | 4 | Per-rail immediate disable |
| pd_req | output | 1 | One-cycle power-down request |
| uv_flag | output | 4 | Sticky undervoltage flags |
| oc_flag | output | 4 | Sticky overcurrent flags |
| scg_flag | output | 4 | Sticky short-circuit flags |

## Verification
Take N as the deglitch length and count from the edge that first samples a steady fault. The flag, `rail_kill` and an immediate `pd_req` all appear at edge N−1 after that first edge, and `pd_req` falls one edge later. A deferred request appears at the edge that samples `slot_end`. A short-circuit on a freshly enabled rail appears `scg_blank_len`+N edges after the enabling edge.

The bench drives stimulus at falling edges and queues each expectation tagged with the exact edge count at which it is due. The monitor compares queued items at the falling edge after that rising edge, and also checks the cycle just before and just after each edge. This catches results that arrive early, late or too long.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    PS_INIT   = 2'd0,
    PS_SEQ    = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_STBY   = 2'd3
  } pwr_state_e;

  // Faults in ACTIVE or STBY request power-down at once; others wait for a slot end.
  function automatic logic pd_is_immediate(input logic [1:0] st);
    return (st == 2'(PS_ACTIVE)) || (st == 2'(PS_STBY));
  endfunction

  // Number of consecutive asserted samples needed to accept a fault.
  function automatic int unsigned dgl_len(input logic long_sel,
                                          input int unsigned short_len,
                                          input int unsigned long_len);
    return long_sel ? long_len : short_len;
  endfunction

endpackage

// File: rtl/rfs_deglitch.sv
module rfs_deglitch #(
  parameter int unsigned SHORT_LEN = 4,
  parameter int unsigned LONG_LEN  = 32,
  localparam int unsigned CW = $clog2(LONG_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic long_sel,
  output logic hit
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    limit = CW'(rfs_pkg::dgl_len(long_sel, SHORT_LEN, LONG_LEN));
    hit   = sample && (cnt == limit - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!sample) begin
      cnt <= '0;
    end else if (cnt < limit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rfs_scg_blank.sv
module rfs_scg_blank #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [BW-1:0] len,
  output logic          blanked
);

  logic          en_q;
  logic [BW-1:0] cnt;
  logic          rise;

  always_comb begin
    rise    = en && !en_q;
    blanked = rise || (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= en;
      if (!en)             cnt <= '0;
      else if (rise)       cnt <= len;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rfs_rail.sv
module rfs_rail #(
  parameter int unsigned SHORT_LEN = 4,
  parameter int unsigned LONG_LEN  = 32,
  parameter int unsigned BW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trans,
  input  logic          uv_mask,
  input  logic          uv_raw,
  input  logic          oc_raw,
  input  logic          scg_raw,
  input  logic          oc_long_sel,
  input  logic [BW-1:0] blank_len,
  input  logic          clr_uv,
  input  logic          clr_oc,
  input  logic          clr_scg,
  output logic          uv_hit,
  output logic          oc_hit,
  output logic          scg_hit,
  output logic          scg_blanked,
  output logic          uv_flag,
  output logic          oc_flag,
  output logic          scg_flag,
  output logic          kill
);

  logic uv_live, oc_live, scg_live;

  always_comb begin
    uv_live  = uv_raw  && en && !trans && !uv_mask;
    oc_live  = oc_raw  && en && !trans;
    scg_live = scg_raw && en && !scg_blanked;
  end

  rfs_scg_blank #(.BW(BW)) u_blank (
    .clk(clk), .rst_n(rst_n), .en(en), .len(blank_len), .blanked(scg_blanked)
  );

  rfs_deglitch #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dg_uv (
    .clk(clk), .rst_n(rst_n), .sample(uv_live), .long_sel(1'b0), .hit(uv_hit)
  );

  rfs_deglitch #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dg_oc (
    .clk(clk), .rst_n(rst_n), .sample(oc_live), .long_sel(oc_long_sel), .hit(oc_hit)
  );

  rfs_deglitch #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dg_scg (
    .clk(clk), .rst_n(rst_n), .sample(scg_live), .long_sel(1'b0), .hit(scg_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_flag  <= 1'b0;
      oc_flag  <= 1'b0;
      scg_flag <= 1'b0;
      kill     <= 1'b0;
    end else begin
      uv_flag  <= (uv_flag  && !clr_uv)  || uv_hit;
      oc_flag  <= (oc_flag  && !clr_oc)  || oc_hit;
      scg_flag <= (scg_flag && !clr_scg) || scg_hit;
      if (!en)                   kill <= 1'b0;
      else if (oc_hit || scg_hit) kill <= 1'b1;
    end
  end

endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int unsigned N_RAILS   = 4,
  parameter int unsigned SHORT_LEN = 4,
  parameter int unsigned LONG_LEN  = 32,
  parameter int unsigned BLANK_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pwr_state,
  input  logic               slot_end,
  input  logic               oc_long_sel,
  input  logic [BLANK_W-1:0] scg_blank_len,
  input  logic [N_RAILS-1:0] rail_en,
  input  logic [N_RAILS-1:0] rail_trans,
  input  logic [N_RAILS-1:0] uv_mask,
  input  logic [N_RAILS-1:0] uv_raw,
  input  logic [N_RAILS-1:0] oc_raw,
  input  logic [N_RAILS-1:0] scg_raw,
  input  logic [N_RAILS-1:0] clr_uv,
  input  logic [N_RAILS-1:0] clr_oc,
  input  logic [N_RAILS-1:0] clr_scg,
  output logic [N_RAILS-1:0] rail_kill,
  output logic               pd_req,
  output logic [N_RAILS-1:0] uv_flag,
  output logic [N_RAILS-1:0] oc_flag,
  output logic [N_RAILS-1:0] scg_flag
);

  logic [N_RAILS-1:0] uv_hit, oc_hit, scg_hit, scg_blanked;
  logic any_hit, imm_mode, imm_hit, def_hit, pd_pend;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    rfs_rail #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .BW(BLANK_W)) u_rail (
      .clk(clk), .rst_n(rst_n),
      .en(rail_en[g]), .trans(rail_trans[g]), .uv_mask(uv_mask[g]),
      .uv_raw(uv_raw[g]), .oc_raw(oc_raw[g]), .scg_raw(scg_raw[g]),
      .oc_long_sel(oc_long_sel), .blank_len(scg_blank_len),
      .clr_uv(clr_uv[g]), .clr_oc(clr_oc[g]), .clr_scg(clr_scg[g]),
      .uv_hit(uv_hit[g]), .oc_hit(oc_hit[g]), .scg_hit(scg_hit[g]),
      .scg_blanked(scg_blanked[g]),
      .uv_flag(uv_flag[g]), .oc_flag(oc_flag[g]), .scg_flag(scg_flag[g]),
      .kill(rail_kill[g])
    );
  end

  always_comb begin
    any_hit  = |(uv_hit | oc_hit | scg_hit);
    imm_mode = rfs_pkg::pd_is_immediate(pwr_state);
    imm_hit  = any_hit && imm_mode;
    def_hit  = any_hit && !imm_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_req  <= 1'b0;
      pd_pend <= 1'b0;
    end else begin
      pd_req  <= imm_hit || (slot_end && (pd_pend || def_hit));
      pd_pend <= (pd_pend || def_hit) && !slot_end;
    end
  end

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned N_RAILS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         pwr_state,
  input logic               slot_end,
  input logic [N_RAILS-1:0] rail_en,
  input logic [N_RAILS-1:0] rail_trans,
  input logic [N_RAILS-1:0] uv_mask,
  input logic [N_RAILS-1:0] scg_blanked,
  input logic [N_RAILS-1:0] rail_kill,
  input logic               pd_req,
  input logic [N_RAILS-1:0] uv_flag,
  input logic [N_RAILS-1:0] oc_flag,
  input logic [N_RAILS-1:0] scg_flag
);

  for (genvar i = 0; i < N_RAILS; i++) begin : g_chk
    AST_TRANS_HIDES_UV: assert property (@(posedge clk) disable iff (!rst_n)
      rail_trans[i] |=> !$rose(uv_flag[i])); // R4
    AST_TRANS_HIDES_OC: assert property (@(posedge clk) disable iff (!rst_n)
      rail_trans[i] |=> !$rose(oc_flag[i])); // R4
    AST_MASK_HIDES_UV: assert property (@(posedge clk) disable iff (!rst_n)
      uv_mask[i] |=> !$rose(uv_flag[i])); // R5
    AST_OC_KILLS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_flag[i]) |-> rail_kill[i]); // R8
    AST_KILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_en[i] |=> !rail_kill[i]); // R8
    AST_SCG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      scg_blanked[i] |=> !$rose(scg_flag[i])); // R9
    AST_UV_IMM_PD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(uv_flag[i]) && $past(rfs_pkg::pd_is_immediate(pwr_state))) |-> pd_req); // R6
  end

  AST_PD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> ($past(slot_end) || $past(rfs_pkg::pd_is_immediate(pwr_state)))); // R7

endmodule

bind rail_fault_supervisor rfs_checker #(.N_RAILS(N_RAILS)) u_rfs_checker (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .slot_end(slot_end),
  .rail_en(rail_en), .rail_trans(rail_trans), .uv_mask(uv_mask),
  .scg_blanked(scg_blanked), .rail_kill(rail_kill), .pd_req(pd_req),
  .uv_flag(uv_flag), .oc_flag(oc_flag), .scg_flag(scg_flag)
);

// File: tb/rail_fault_supervisor_tb.sv
module rail_fault_supervisor_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   pwr_state = 2'd2;
  logic         slot_end = 1'b0;
  logic         oc_long_sel = 1'b0;
  logic [7:0]   scg_blank_len = 8'd6;
  logic [N-1:0] rail_en = '1, rail_trans = '0, uv_mask = '0;
  logic [N-1:0] uv_raw = '0, oc_raw = '0, scg_raw = '0;
  logic [N-1:0] clr_uv = '0, clr_oc = '0, clr_scg = '0;
  logic [N-1:0] rail_kill, uv_flag, oc_flag, scg_flag;
  logic         pd_req;

  rail_fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .slot_end(slot_end),
    .oc_long_sel(oc_long_sel), .scg_blank_len(scg_blank_len),
    .rail_en(rail_en), .rail_trans(rail_trans), .uv_mask(uv_mask),
    .uv_raw(uv_raw), .oc_raw(oc_raw), .scg_raw(scg_raw),
    .clr_uv(clr_uv), .clr_oc(clr_oc), .clr_scg(clr_scg),
    .rail_kill(rail_kill), .pd_req(pd_req),
    .uv_flag(uv_flag), .oc_flag(oc_flag), .scg_flag(scg_flag)
  );

  always #4 clk = ~clk;  // 125 MHz

  localparam int S_UV = 0, S_OC = 1, S_SCG = 2, S_KILL = 3, S_PD = 4;

  typedef struct {
    int    cyc;
    int    sel;
    int    idx;
    logic  exp;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   ecount = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) ecount <= ecount + 1;

  function automatic logic probe(input int sel, input int idx);
    case (sel)
      S_UV:    return uv_flag[idx];
      S_OC:    return oc_flag[idx];
      S_SCG:   return scg_flag[idx];
      S_KILL:  return rail_kill[idx];
      default: return pd_req;
    endcase
  endfunction

  task automatic expect_at(input int cyc, input int sel, input int idx,
                           input logic v, input string tag);
    exp_t it;
    int   pos;
    it.cyc = cyc; it.sel = sel; it.idx = idx; it.exp = v; it.tag = tag;
    pos = sb.size();
    for (int k = 0; k < sb.size(); k++) begin
      if (sb[k].cyc > cyc) begin pos = k; break; end
    end
    sb.insert(pos, it);
  endtask

  // Monitor: compares queued expectations at the falling edge after their rising edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= ecount) begin
      exp_t it;
      logic act;
      it = sb.pop_front();
      checks++;
      act = probe(it.sel, it.idx);
      if (it.cyc != ecount || act !== it.exp) begin
        errors++;
        $display("FAIL %s: edge %0d sel %0d rail %0d actual %b expected %b",
                 it.tag, ecount, it.sel, it.idx, act, it.exp);
      end
    end
  end

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (sb.size() > 0) begin
      errors += sb.size();
      checks += sb.size();
      $display("FAIL %s: %0d expectations never reached, actual none expected all",
               sb[0].tag, sb.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int e;
    // R1 reset state
    expect_at(2, S_PD, 0, 1'b0, "R1");
    expect_at(2, S_KILL, 0, 1'b0, "R1");
    expect_at(2, S_UV, 0, 1'b0, "R1");
    expect_at(2, S_OC, 3, 1'b0, "R1");
    expect_at(2, S_SCG, 1, 1'b0, "R1");
    cyc_wait(4);
    rst_n = 1'b1;
    cyc_wait(10);

    // R2: a three-sample glitch is rejected
    e = ecount;
    expect_at(e + 4, S_UV, 0, 1'b0, "R2");
    uv_raw[0] = 1'b1;
    cyc_wait(3);
    uv_raw[0] = 1'b0;
    cyc_wait(4);

    // R2/R6/R8: steady undervoltage in ACTIVE
    e = ecount;
    expect_at(e + 3, S_UV, 0, 1'b0, "R2");
    expect_at(e + 4, S_UV, 0, 1'b1, "R2");
    expect_at(e + 3, S_PD, 0, 1'b0, "R6");
    expect_at(e + 4, S_PD, 0, 1'b1, "R6");
    expect_at(e + 5, S_PD, 0, 1'b0, "R6");
    expect_at(e + 4, S_KILL, 0, 1'b0, "R8");
    uv_raw[0] = 1'b1;
    cyc_wait(6);
    uv_raw[0] = 1'b0;
    e = ecount;
    expect_at(e + 1, S_UV, 0, 1'b0, "R10");
    clr_uv[0] = 1'b1;
    cyc_wait(1);
    clr_uv[0] = 1'b0;
    cyc_wait(2);

    // R5: masked undervoltage
    e = ecount;
    expect_at(e + 4, S_PD, 0, 1'b0, "R5");
    expect_at(e + 5, S_PD, 0, 1'b0, "R5");
    expect_at(e + 10, S_UV, 1, 1'b0, "R5");
    uv_mask[1] = 1'b1;
    uv_raw[1] = 1'b1;
    cyc_wait(12);
    uv_raw[1] = 1'b0;
    uv_mask[1] = 1'b0;
    cyc_wait(2);

    // R4: transition blanks UV and OC, counting restarts afterwards
    e = ecount;
    expect_at(e + 20, S_UV, 2, 1'b0, "R4");
    expect_at(e + 20, S_OC, 2, 1'b0, "R4");
    expect_at(e + 20, S_KILL, 2, 1'b0, "R4");
    rail_trans[2] = 1'b1;
    uv_raw[2] = 1'b1;
    oc_raw[2] = 1'b1;
    cyc_wait(20);
    e = ecount;
    expect_at(e + 3, S_OC, 2, 1'b0, "R4");
    expect_at(e + 4, S_OC, 2, 1'b1, "R4");
    expect_at(e + 4, S_UV, 2, 1'b1, "R4");
    expect_at(e + 4, S_KILL, 2, 1'b1, "R8");
    expect_at(e + 4, S_PD, 0, 1'b1, "R6");
    rail_trans[2] = 1'b0;
    cyc_wait(6);
    uv_raw[2] = 1'b0;
    oc_raw[2] = 1'b0;
    e = ecount;
    expect_at(e + 1, S_KILL, 2, 1'b0, "R8");
    expect_at(e + 1, S_OC, 2, 1'b0, "R10");
    clr_uv[2] = 1'b1;
    clr_oc[2] = 1'b1;
    rail_en[2] = 1'b0;
    cyc_wait(1);
    clr_uv[2] = 1'b0;
    clr_oc[2] = 1'b0;
    rail_en[2] = 1'b1;
    cyc_wait(10);

    // R3: long overcurrent deglitch
    oc_long_sel = 1'b1;
    e = ecount;
    expect_at(e + 4, S_OC, 3, 1'b0, "R3");
    expect_at(e + 31, S_OC, 3, 1'b0, "R3");
    expect_at(e + 32, S_OC, 3, 1'b1, "R3");
    expect_at(e + 32, S_KILL, 3, 1'b1, "R3");
    expect_at(e + 32, S_PD, 0, 1'b1, "R3");
    oc_raw[3] = 1'b1;
    cyc_wait(34);
    oc_raw[3] = 1'b0;
    oc_long_sel = 1'b0;
    clr_oc[3] = 1'b1;
    rail_en[3] = 1'b0;
    cyc_wait(1);
    clr_oc[3] = 1'b0;
    rail_en[3] = 1'b1;
    cyc_wait(10);

    // R7: deferred request during sequencing, rail still killed at once
    pwr_state = 2'd1;
    e = ecount;
    expect_at(e + 4, S_OC, 1, 1'b1, "R7");
    expect_at(e + 4, S_KILL, 1, 1'b1, "R8");
    expect_at(e + 4, S_PD, 0, 1'b0, "R7");
    expect_at(e + 5, S_PD, 0, 1'b0, "R7");
    expect_at(e + 6, S_PD, 0, 1'b0, "R7");
    expect_at(e + 7, S_PD, 0, 1'b1, "R7");
    expect_at(e + 8, S_PD, 0, 1'b0, "R7");
    oc_raw[1] = 1'b1;
    cyc_wait(6);
    slot_end = 1'b1;
    cyc_wait(1);
    slot_end = 1'b0;
    oc_raw[1] = 1'b0;
    cyc_wait(4);
    e = ecount;
    expect_at(e + 1, S_PD, 0, 1'b0, "R7");
    slot_end = 1'b1;
    cyc_wait(1);
    slot_end = 1'b0;
    pwr_state = 2'd2;
    clr_oc[1] = 1'b1;
    rail_en[1] = 1'b0;
    cyc_wait(1);
    clr_oc[1] = 1'b0;
    rail_en[1] = 1'b1;
    cyc_wait(10);

    // R9: short-circuit blanking after enable
    rail_en[0] = 1'b0;
    cyc_wait(2);
    e = ecount;
    expect_at(e + 10, S_SCG, 0, 1'b0, "R9");
    expect_at(e + 11, S_SCG, 0, 1'b1, "R9");
    expect_at(e + 11, S_KILL, 0, 1'b1, "R9");
    expect_at(e + 11, S_PD, 0, 1'b1, "R9");
    rail_en[0] = 1'b1;
    scg_raw[0] = 1'b1;
    cyc_wait(13);
    scg_raw[0] = 1'b0;
    clr_scg[0] = 1'b1;
    cyc_wait(1);
    clr_scg[0] = 1'b0;
    cyc_wait(2);

    // R10: a fault at the same edge as a clear leaves the flag set
    e = ecount;
    expect_at(e + 4, S_UV, 0, 1'b1, "R10");
    expect_at(e + 5, S_UV, 0, 1'b0, "R10");
    clr_uv[0] = 1'b1;
    uv_raw[0] = 1'b1;
    cyc_wait(6);
    clr_uv[0] = 1'b0;
    uv_raw[0] = 1'b0;
    cyc_wait(5);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule